// File: doc/BRIEF.md
# Two-mode supervisory watchdog with keyed reload

This block is a watchdog timer that sits in a board management controller. Software reaches it through a byte-wide register port with an address, write data, a write strobe and combinational read data. Three registers hold the mode, the time-out in whole seconds and the reload key. A countdown is loaded with the time-out only when the key register receives one specific byte. After that it counts down once per second, using a prescaler whose divisor is a parameter.

There are two enable bits. One runs the watchdog in normal mode and the other in recovery mode. When the count runs out, three things can happen:
- The block can pulse a system reset for a fixed number of clock cycles.
- It can pull an active-low time-out line low and hold it there until hardware reset.
- It raises a sticky recovery flag if recovery mode was enabled, so the next boot takes the failsafe path.

A lock bit prevents software from turning the watchdog off again. The intended setup sequence is: disable, write the time-out, kick, then enable.

Top module: `boot_watchdog`

## Requirements
- R1: The address map is as follows, and addresses not listed read 0.
  - Address 0 is control: bit 0 is normal enable, bit 1 is recovery enable, bit 2 is lock, bit 6 is reset-on-expiry and bit 7 is time-out-line-on-expiry. Bits 3 to 5 read 0.
  - Address 1 is the 8-bit time-out in seconds.
  - Address 2 is the kick register, which always reads 0.
- R2: After hardware reset, the following hold:
  - Control, time-out and counter are 0.
  - `sys_rst_o` is 0, `timeout_no` is 1 and `recov_o` is 0.
- R3: Writing 0x6B to address 2 loads the counter from the time-out register and restarts the one-second prescaler. Expiry then follows 1 + T·TICK_DIV cycles after the kick edge.
- R4: Writing any other value to address 2 leaves the counter and the prescaler untouched.
- R5: While bit 0 or bit 1 is set, the counter falls by one every TICK_DIV cycles. Expiry acts in the cycle after the count is seen at 0.
- R6: With both enable bits clear, nothing counts and nothing expires.
- R7: A time-out of 0, followed by a kick and an enable, expires one cycle after the enabling write.
- R8: At expiry with bit 6 set, `sys_rst_o` is high for exactly RST_PULSE cycles. With bit 6 clear it stays low.
- R9: At expiry with bit 7 set, `timeout_no` goes low and stays low until hardware reset.
- R10: At expiry with bit 1 set, `recov_o` rises and holds until hardware reset. With only bit 0 set it stays low.
- R11: Once bit 2 is set, writes cannot clear bits 0, 1 or 2 until hardware reset. Bits 6 and 7 stay writable.
- R12: After one expiry, no further expiry occurs until hardware reset, even if software kicks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per high cycle |
| rdata_o | output | 8 | Read data for `addr_i` |
| sys_rst_o | output | 1 | System reset pulse |
| timeout_no | output | 1 | Active-low time-out line, sticky |
| recov_o | output | 1 | Recovery watchdog fired, sticky |

## Verification
Two situations are hard to reach from the ports: a kick that lands part-way through a second, and a rejected kick that must leave the phase of the second untouched. The stimulus reaches both by writing the key, or a near-miss byte, a fixed number of cycles after enabling. It then measures the distance from that write edge to the fall of `timeout_no` and compares it with the value computed from T·TICK_DIV+1. A behavioural reference model runs alongside and compares every output on every cycle. This includes the lock path, where an attempted clear must be overruled.

// File: rtl/boot_wdg_pkg.sv
package boot_wdg_pkg;
  localparam int unsigned DW = 8;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_TMO  = 1;
  localparam int unsigned A_KICK = 2;

  localparam logic [DW-1:0] KICK_KEY = 8'h6B;

  localparam int unsigned B_EN_NORM  = 0;
  localparam int unsigned B_EN_RECOV = 1;
  localparam int unsigned B_LOCK     = 2;
  localparam int unsigned B_RST_EN   = 6;
  localparam int unsigned B_TMO_EN   = 7;

  typedef struct packed {
    logic tmo_en;
    logic rst_en;
    logic lock;
    logic en_recov;
    logic en_norm;
  } ctrl_t;
endpackage

// File: rtl/boot_wdg_regs.sv
module boot_wdg_regs
  import boot_wdg_pkg::*;
#(
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] tmo_o,
  output logic          kick_o,
  output logic [DW-1:0] rdata_o
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] tmo_q;
  logic          wr_ctrl, wr_tmo;

  assign wr_ctrl = we_i && (addr_i == AW'(A_CTRL));
  assign wr_tmo  = we_i && (addr_i == AW'(A_TMO));
  assign kick_o  = we_i && (addr_i == AW'(A_KICK)) && (wdata_i == KICK_KEY);

  // lock keeps enables and itself set; only reset clears them
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en_norm  = wdata_i[B_EN_NORM]  | (ctrl_q.lock & ctrl_q.en_norm);
      ctrl_d.en_recov = wdata_i[B_EN_RECOV] | (ctrl_q.lock & ctrl_q.en_recov);
      ctrl_d.lock     = wdata_i[B_LOCK]     | ctrl_q.lock;
      ctrl_d.rst_en   = wdata_i[B_RST_EN];
      ctrl_d.tmo_en   = wdata_i[B_TMO_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_tmo) tmo_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CTRL)) begin
      rdata_o[B_EN_NORM]  = ctrl_q.en_norm;
      rdata_o[B_EN_RECOV] = ctrl_q.en_recov;
      rdata_o[B_LOCK]     = ctrl_q.lock;
      rdata_o[B_RST_EN]   = ctrl_q.rst_en;
      rdata_o[B_TMO_EN]   = ctrl_q.tmo_en;
    end else if (addr_i == AW'(A_TMO)) begin
      rdata_o = tmo_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign tmo_o  = tmo_q;

  p_lock_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.lock |=> (ctrl_q.lock
                     && (ctrl_q.en_norm  || !$past(ctrl_q.en_norm))
                     && (ctrl_q.en_recov || !$past(ctrl_q.en_recov))));
endmodule

// File: rtl/boot_wdg_tick.sv
module boot_wdg_tick #(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pcnt_q;

  assign tick_o = run_i && (pcnt_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         pcnt_q <= '0;
    else if (!run_i || clr_i || tick_o)  pcnt_q <= '0;
    else                                 pcnt_q <= pcnt_q + 1'b1;
  end

  p_tick_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pcnt_q == '0));
endmodule

// File: rtl/boot_wdg_core.sv
module boot_wdg_core
  import boot_wdg_pkg::*;
#(
  parameter int unsigned RST_PULSE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] tmo_i,
  input  logic          kick_i,
  input  logic          tick_i,
  output logic          run_o,
  output logic          sys_rst_o,
  output logic          timeout_no,
  output logic          recov_o
);
  localparam int unsigned RCW = $clog2(RST_PULSE + 1);

  logic [DW-1:0]  cnt_q;
  logic [RCW-1:0] rcnt_q;
  logic           fired_q, tmo_nq, recov_q, expire;

  assign run_o  = (ctrl_i.en_norm || ctrl_i.en_recov) && !fired_q;
  assign expire = run_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rcnt_q  <= '0;
      fired_q <= 1'b0;
      tmo_nq  <= 1'b1;
      recov_q <= 1'b0;
    end else begin
      if (kick_i)                         cnt_q <= tmo_i;
      else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;

      if (expire && ctrl_i.rst_en)        rcnt_q <= RCW'(RST_PULSE);
      else if (rcnt_q != '0)              rcnt_q <= rcnt_q - 1'b1;

      if (expire) begin
        fired_q <= 1'b1;
        if (ctrl_i.tmo_en)   tmo_nq  <= 1'b0;
        if (ctrl_i.en_recov) recov_q <= 1'b1;
      end
    end
  end

  assign sys_rst_o  = (rcnt_q != '0);
  assign timeout_no = tmo_nq;
  assign recov_o    = recov_q;

  // pulse length checker
  logic [RCW-1:0] hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_q <= '0;
    else if (sys_rst_o) hi_q <= hi_q + 1'b1;
    else                hi_q <= '0;
  end

  p_rst_short_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (hi_q < RCW'(RST_PULSE)));
  p_rst_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (hi_q == RCW'(RST_PULSE)));
  p_tmo_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !timeout_no |=> !timeout_no);
  p_recov_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_o |=> recov_o);
  p_kick_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == $past(tmo_i)));
endmodule

// File: rtl/boot_watchdog.sv
module boot_watchdog
  import boot_wdg_pkg::*;
#(
  parameter int unsigned AW        = 2,
  parameter int unsigned TICK_DIV  = 50_000_000,
  parameter int unsigned RST_PULSE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          we_i,
  output logic [7:0]    rdata_o,
  output logic          sys_rst_o,
  output logic          timeout_no,
  output logic          recov_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] tmo;
  logic          kick, run, tick;

  boot_wdg_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .ctrl_o  (ctrl),
    .tmo_o   (tmo),
    .kick_o  (kick),
    .rdata_o (rdata_o)
  );

  boot_wdg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (kick),
    .tick_o (tick)
  );

  boot_wdg_core #(.RST_PULSE(RST_PULSE)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .tmo_i      (tmo),
    .kick_i     (kick),
    .tick_i     (tick),
    .run_o      (run),
    .sys_rst_o  (sys_rst_o),
    .timeout_no (timeout_no),
    .recov_o    (recov_o)
  );
endmodule

// File: tb/boot_watchdog_tb.sv
module boot_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 8;
  localparam int PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata_o;
  logic       sys_rst_o, timeout_no, recov_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, seen_rst = 0;

  // reference model state
  int m_ctrl, m_tmo, m_cnt, m_pre, m_rcnt;
  bit m_fired, m_tmo_n, m_recov;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_watchdog #(.AW(2), .TICK_DIV(DIV), .RST_PULSE(PULSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata_o), .sys_rst_o(sys_rst_o), .timeout_no(timeout_no), .recov_o(recov_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_ctrl = 0; m_tmo = 0; m_cnt = 0; m_pre = 0; m_rcnt = 0;
      m_fired = 0; m_tmo_n = 1; m_recov = 0;
    end else begin
      bit run, exp_now, kick, tick;
      int nc;
      run     = ((m_ctrl & 3) != 0) && !m_fired;
      exp_now = run && (m_cnt == 0);
      kick    = we && addr == 2 && wdata == 8'h6B;
      tick    = run && (m_pre == DIV - 1);
      if (m_rcnt > 0) m_rcnt--;
      if (exp_now) begin
        m_fired = 1;
        if (m_ctrl & 8'h40) m_rcnt = PULSE;
        if (m_ctrl & 8'h80) m_tmo_n = 0;
        if (m_ctrl & 8'h02) m_recov = 1;
      end
      if (kick || !run || tick) m_pre = 0; else m_pre++;
      if (kick) m_cnt = m_tmo;
      else if (tick && m_cnt > 0) m_cnt--;
      if (we && addr == 0) begin
        nc = wdata & 8'hC7;
        if (m_ctrl & 4) nc |= (m_ctrl & 7);
        m_ctrl = nc;
      end
      if (we && addr == 1) m_tmo = wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (sys_rst_o) seen_rst = 1;
      check(sys_rst_o, m_rcnt > 0, "R8 model sys_rst_o");
      check(timeout_no, m_tmo_n, "R9 model timeout_no");
      check(recov_o, m_recov, "R10 model recov_o");
      check(rdata_o, addr == 0 ? m_ctrl : addr == 1 ? m_tmo : 0, "R1 model rdata_o");
    end
  end

  task automatic hw_reset();
    @(negedge clk); #1 rst_ni = 0; we = 0;
    repeat (2) @(negedge clk);
    #1 rst_ni = 1;
    seen_rst = 0;
  endtask

  task automatic wr(input int a, input int d, output int t);
    @(negedge clk); #1 addr = a[1:0]; wdata = d[7:0]; we = 1;
    @(posedge clk); #1 we = 0; t = cyc;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); #1 addr = a[1:0]; #1 check(rdata_o, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic time_to_tmo(input int t0, output int d);
    while (timeout_no !== 1'b0) @(negedge clk);
    d = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t, t0, d, n;
    hw_reset();
    // R2 reset state
    #1 check(sys_rst_o, 0, "R2 sys_rst_o");
    check(timeout_no, 1, "R2 timeout_no");
    check(recov_o, 0, "R2 recov_o");
    rd(0, 0, "R2 ctrl"); rd(1, 0, "R2 tmo");

    // R1 map and readback
    wr(0, 8'hC0, t); rd(0, 8'hC0, "R1 ctrl readback");
    wr(0, 8'h38, t); rd(0, 8'h00, "R1 bits 3..5 read 0");
    wr(1, 8'h5A, t); rd(1, 8'h5A, "R1 tmo readback");
    wr(2, 8'h5A, t); rd(2, 0, "R1 kick reads 0");
    rd(3, 0, "R1 unused address");

    // R5 R8 R9 normal mode with reset pulse
    hw_reset();
    wr(1, 3, t); wr(2, 8'h6B, t); wr(0, 8'hC1, t0);
    time_to_tmo(t0, d);
    check(d, 3*DIV + 1, "R5 expiry delay");
    check(sys_rst_o, 1, "R8 pulse with expiry");
    n = 0;
    while (sys_rst_o) begin @(negedge clk); n++; end
    check(n, PULSE, "R8 pulse length");
    check(recov_o, 0, "R10 no flag in normal mode");
    // R12 no second expiry
    seen_rst = 0;
    wr(2, 8'h6B, t); idle(5*DIV);
    check(seen_rst, 0, "R12 single shot");
    check(timeout_no, 0, "R9 line held low");

    // R3 good kick restarts mid-second
    hw_reset();
    wr(1, 2, t); wr(2, 8'h6B, t); wr(0, 8'h81, t0);
    idle(12);
    wr(2, 8'h6B, t);
    time_to_tmo(t, d);
    check(d, 2*DIV + 1, "R3 delay from kick");
    check(seen_rst, 0, "R8 no pulse when disabled");

    // R4 wrong key ignored
    hw_reset();
    wr(1, 2, t); wr(2, 8'h6B, t); wr(0, 8'h81, t0);
    idle(4);
    wr(2, 8'h6A, t);
    idle(3);
    wr(2, 8'h00, t);
    time_to_tmo(t0, d);
    check(d, 2*DIV + 1, "R4 delay unchanged by bad kicks");

    // R6 disabled, then R7 zero time-out in recovery mode
    hw_reset();
    wr(1, 0, t); wr(2, 8'h6B, t); wr(0, 8'hC0, t);
    idle(6*DIV);
    check(timeout_no, 1, "R6 no expiry disabled");
    check(seen_rst, 0, "R6 no pulse disabled");
    wr(0, 8'hC2, t0);
    time_to_tmo(t0, d);
    check(d, 1, "R7 immediate expiry");
    check(recov_o, 1, "R10 recovery flag");
    idle(10);
    check(recov_o, 1, "R10 flag held");
    hw_reset();
    #1 check(recov_o, 0, "R2 flag cleared by reset");
    check(timeout_no, 1, "R2 line released by reset");

    // R11 lock
    wr(1, 100, t); wr(2, 8'h6B, t); wr(0, 8'h85, t);
    rd(0, 8'h85, "R11 locked ctrl");
    wr(0, 8'h40, t); rd(0, 8'h45, "R11 clear refused");
    wr(0, 8'h02, t); rd(0, 8'h07, "R11 set allowed, 6/7 writable");
    hw_reset();
    rd(0, 0, "R11 lock released by reset");

    idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule